// File: doc/BRIEF.md
# Width-Converting Stream Buffer

This block sits between two valid/ready streams whose data widths differ. It holds a single storage register that is as wide as the wider of the two ports. Both widths are parameters, and the relation between them fixes the operating variant when the design is elaborated:

- If the input is narrower than the output, the block packs. It collects narrow words until one full output word is assembled, then offers that word.
- If the input is wider than the output, the block unpacks. It takes one wide word and releases it as a series of narrow pieces.
- If the widths are equal, the block is a one-entry FIFO.

The wider width must be a whole multiple of the narrower width. No partial-word masking exists. A full wide word always moves in or out in one transfer. A `fill` output reports how many narrow slots are currently occupied. A synchronous `flush` input returns the block to empty. The reset is asynchronous and active low.

In this document, RATIO means the larger width divided by the smaller width. A write handshake is `in_valid` and `in_ready` both high at a rising clock edge. A read handshake is `out_valid` and `out_ready` both high at a rising clock edge.

Top module: `width_conv_buf`

## Requirements
- R1: After reset, `fill` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: In pack mode, each write handshake raises `fill` by one. `in_ready` is high exactly while `fill` is below RATIO, and `out_valid` is high exactly when `fill` equals RATIO.
- R3: In pack mode, input word k (counting from 0 since the register was last empty) occupies bits [k*IN_W +: IN_W] of `out_data`. The first word therefore lands in the least significant bits.
- R4: In pack mode and in equal-width mode, a read handshake empties the register at that edge. After the edge `fill` is 0, `out_valid` is 0 and `out_data` is all zeros.
- R5: In unpack mode, `in_ready` is high only when `fill` is 0. A write handshake loads the whole input word and sets `fill` to RATIO.
- R6: In unpack mode, `out_valid` is high whenever `fill` is nonzero. `out_data` shows the least significant unsent piece. Each read handshake moves to the next more significant piece and lowers `fill` by one.
- R7: In equal-width mode, `fill` is only ever 0 or 1. A write is accepted only when `fill` is 0, and the stored word is presented on `out_data` unchanged.
- R8: With `flush` high at a clock edge, the block is empty after that edge, whatever handshake is attempted in the same cycle.
- R9: A write presented while `in_ready` is low changes neither `fill` nor `out_data`.
- R10: `fill` never exceeds RATIO.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `fill` hold, and `out_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear to the empty state |
| in_valid | input | 1 | Write request |
| in_data | input | IN_W | Write data |
| in_ready | output | 1 | Buffer can take a write |
| out_valid | output | 1 | Read data is available |
| out_data | output | OUT_W | Read data |
| out_ready | input | 1 | Consumer takes the read data |
| fill | output | $clog2(RATIO+1) | Count of occupied narrow slots |

## Verification
The bound checker watches, on every cycle, the relations between the handshakes and the `fill` count:
- the count bound;
- the increment, load and decrement rules;
- the effect of `flush`;
- that a refused write changes nothing;
- that a stalled output holds steady.

Only the bench's scenarios can show the data-ordering rules: where each packed input word lands, which piece an unpack read exposes, and that equal-width data passes through untouched. These need known words pushed through the block and compared with a reference model. The bench runs separate instances for pack, unpack and equal widths.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

   typedef enum logic [1:0] {
      WCB_PACK   = 2'd0,
      WCB_UNPACK = 2'd1,
      WCB_PASS   = 2'd2
   } wcb_mode_e;

   function automatic int wcb_ratio(input int in_w, input int out_w);
      if (in_w >= out_w) return in_w / out_w;
      return out_w / in_w;
   endfunction

   function automatic int wcb_fill_w(input int ratio);
      return (ratio < 2) ? 1 : $clog2(ratio + 1);
   endfunction

   function automatic wcb_mode_e wcb_mode(input int in_w, input int out_w);
      if (in_w < out_w) return WCB_PACK;
      if (in_w > out_w) return WCB_UNPACK;
      return WCB_PASS;
   endfunction

endpackage

// File: rtl/wcb_pack.sv
module wcb_pack #(
   parameter int IN_W   = 8,
   parameter int OUT_W  = 32,
   parameter int RATIO  = 4,
   parameter int FILL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_data,
   input  logic              out_ready,
   output logic [FILL_W-1:0] fill
);

   logic [FILL_W-1:0] cnt_q;
   logic [OUT_W-1:0]  acc_q;
   logic              full, wr_go, rd_go;

   assign full      = (cnt_q == FILL_W'(RATIO));
   assign in_ready  = !full;
   assign out_valid = full;
   assign wr_go     = in_valid && !full;
   assign rd_go     = full && out_ready;
   assign out_data  = acc_q;
   assign fill      = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (flush) cnt_q <= '0;
      else if (wr_go) cnt_q <= cnt_q + FILL_W'(1);
      else if (rd_go) cnt_q <= '0;
   end

   for (genvar s = 0; s < RATIO; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            acc_q[s*IN_W +: IN_W] <= '0;
         else if (flush || rd_go)
            acc_q[s*IN_W +: IN_W] <= '0;
         else if (wr_go && cnt_q == FILL_W'(s))
            acc_q[s*IN_W +: IN_W] <= in_data;
      end
   end

endmodule

// File: rtl/wcb_unpack.sv
module wcb_unpack #(
   parameter int IN_W   = 32,
   parameter int OUT_W  = 8,
   parameter int RATIO  = 4,
   parameter int FILL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_data,
   input  logic              out_ready,
   output logic [FILL_W-1:0] fill
);

   localparam int REST_W = IN_W - OUT_W;

   logic [FILL_W-1:0] left_q;
   logic [IN_W-1:0]   word_q;
   logic              empty, wr_go, rd_go;

   assign empty     = (left_q == '0);
   assign in_ready  = empty;
   assign out_valid = !empty;
   assign wr_go     = in_valid && empty;
   assign rd_go     = !empty && out_ready;
   assign out_data  = word_q[OUT_W-1:0];
   assign fill      = left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         word_q <= '0;
      end else if (flush) begin
         left_q <= '0;
         word_q <= '0;
      end else if (wr_go) begin
         left_q <= FILL_W'(RATIO);
         word_q <= in_data;
      end else if (rd_go) begin
         left_q <= left_q - FILL_W'(1);
         word_q <= {{OUT_W{1'b0}}, word_q[IN_W-1 -: REST_W]};
      end
   end

endmodule

// File: rtl/wcb_pass.sv
module wcb_pass #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         in_ready,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   input  logic         out_ready,
   output logic         fill
);

   logic         full_q;
   logic [W-1:0] hold_q;

   assign in_ready  = !full_q;
   assign out_valid = full_q;
   assign out_data  = hold_q;
   assign fill      = full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         hold_q <= '0;
      end else if (flush) begin
         full_q <= 1'b0;
         hold_q <= '0;
      end else if (!full_q && in_valid) begin
         full_q <= 1'b1;
         hold_q <= in_data;
      end else if (full_q && out_ready) begin
         full_q <= 1'b0;
         hold_q <= '0;
      end
   end

endmodule

// File: rtl/width_conv_buf.sv
module width_conv_buf
   import wcb_pkg::*;
#(
   parameter int IN_W  = 8,
   parameter int OUT_W = 32,
   localparam int RATIO  = wcb_ratio(IN_W, OUT_W),
   localparam int FILL_W = wcb_fill_w(RATIO)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_data,
   input  logic              out_ready,
   output logic [FILL_W-1:0] fill
);

   localparam wcb_mode_e MODE = wcb_mode(IN_W, OUT_W);

   if (IN_W < 1 || OUT_W < 1) begin : g_bad_width
      $error("width_conv_buf: widths must be positive");
   end
   if ((IN_W >= OUT_W && (IN_W % OUT_W) != 0) ||
       (IN_W <  OUT_W && (OUT_W % IN_W) != 0)) begin : g_bad_ratio
      $error("width_conv_buf: wider width must be a whole multiple of the narrower");
   end

   if (MODE == WCB_PACK) begin : g_pack
      wcb_pack #(.IN_W(IN_W), .OUT_W(OUT_W), .RATIO(RATIO), .FILL_W(FILL_W)) u_core (
         .clk(clk), .rst_n(rst_n), .flush(flush),
         .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
         .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
         .fill(fill));
   end else if (MODE == WCB_UNPACK) begin : g_unpack
      wcb_unpack #(.IN_W(IN_W), .OUT_W(OUT_W), .RATIO(RATIO), .FILL_W(FILL_W)) u_core (
         .clk(clk), .rst_n(rst_n), .flush(flush),
         .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
         .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
         .fill(fill));
   end else begin : g_pass
      logic fill_bit;
      wcb_pass #(.W(OUT_W)) u_core (
         .clk(clk), .rst_n(rst_n), .flush(flush),
         .in_valid(in_valid), .in_data(OUT_W'(in_data)), .in_ready(in_ready),
         .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
         .fill(fill_bit));
      assign fill = FILL_W'(fill_bit);
   end

endmodule

// File: rtl/wcb_check.sv
module wcb_check
   import wcb_pkg::*;
#(
   parameter int IN_W  = 8,
   parameter int OUT_W = 32,
   localparam int RATIO  = wcb_ratio(IN_W, OUT_W),
   localparam int FILL_W = wcb_fill_w(RATIO)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              in_valid,
   input logic [IN_W-1:0]   in_data,
   input logic              in_ready,
   input logic              out_valid,
   input logic [OUT_W-1:0]  out_data,
   input logic              out_ready,
   input logic [FILL_W-1:0] fill
);

   localparam wcb_mode_e MODE = wcb_mode(IN_W, OUT_W);

   logic wr_hs, rd_hs;
   assign wr_hs = in_valid && in_ready && !flush;
   assign rd_hs = out_valid && out_ready && !flush;

   assert_fill_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FILL_W'(RATIO));

   assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (fill == '0) && !out_valid && in_ready);

   assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !flush) |=> out_valid && $stable(out_data) && $stable(fill));

   assert_refused_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready && !out_ready && !flush) |=> $stable(fill) && $stable(out_data));

   if (MODE == WCB_UNPACK) begin : g_unp
      assert_load_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
         wr_hs |=> fill == FILL_W'(RATIO));
      assert_ready_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
         in_ready |-> fill == '0);
      assert_piece_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
         rd_hs |=> fill == FILL_W'($past(fill) - FILL_W'(1)));
   end else begin : g_acc
      assert_write_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
         wr_hs |=> fill == FILL_W'($past(fill) + FILL_W'(1)));
      assert_full_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> !in_ready && fill == FILL_W'(RATIO));
      assert_read_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
         rd_hs |=> fill == '0 && !out_valid && out_data == '0);
   end

endmodule

bind width_conv_buf wcb_check #(.IN_W(IN_W), .OUT_W(OUT_W)) u_wcb_check (.*);

// File: tb/test_width_conv_buf.sv
module test_width_conv_buf;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int total = 0;
   int bad = 0;

   // pack instance: 8 -> 32
   logic        p_iv = 0, p_or = 0, p_fl = 0, p_ir, p_ov;
   logic [7:0]  p_id = '0;
   logic [31:0] p_od;
   logic [2:0]  p_fill;
   // unpack instance: 32 -> 8
   logic        u_iv = 0, u_or = 0, u_fl = 0, u_ir, u_ov;
   logic [31:0] u_id = '0;
   logic [7:0]  u_od;
   logic [2:0]  u_fill;
   // equal instance: 16 -> 16
   logic        e_iv = 0, e_or = 0, e_fl = 0, e_ir, e_ov;
   logic [15:0] e_id = '0, e_od;
   logic        e_fill;

   width_conv_buf #(.IN_W(8), .OUT_W(32)) i_width_conv_buf (
      .clk(clk), .rst_n(rst_n), .flush(p_fl), .in_valid(p_iv), .in_data(p_id),
      .in_ready(p_ir), .out_valid(p_ov), .out_data(p_od), .out_ready(p_or), .fill(p_fill));
   width_conv_buf #(.IN_W(32), .OUT_W(8)) i_width_conv_buf_unp (
      .clk(clk), .rst_n(rst_n), .flush(u_fl), .in_valid(u_iv), .in_data(u_id),
      .in_ready(u_ir), .out_valid(u_ov), .out_data(u_od), .out_ready(u_or), .fill(u_fill));
   width_conv_buf #(.IN_W(16), .OUT_W(16)) i_width_conv_buf_eq (
      .clk(clk), .rst_n(rst_n), .flush(e_fl), .in_valid(e_iv), .in_data(e_id),
      .in_ready(e_ir), .out_valid(e_ov), .out_data(e_od), .out_ready(e_or), .fill(e_fill));

   // reference models
   int          pm_cnt = 0;
   logic [31:0] pm_data = '0;
   int          um_cnt = 0;
   logic [31:0] um_data = '0;
   int          em_cnt = 0;
   logic [15:0] em_data = '0;

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic p_cmp();
      chk("R2", "pack in_ready", 64'(p_ir), 64'(pm_cnt < 4));
      chk("R2", "pack out_valid", 64'(p_ov), 64'(pm_cnt == 4));
      chk("R3", "pack out_data", 64'(p_od), 64'(pm_data));
      chk("R10", "pack fill", 64'(p_fill), 64'(pm_cnt));
   endtask

   task automatic u_cmp();
      chk("R5", "unpack in_ready", 64'(u_ir), 64'(um_cnt == 0));
      chk("R6", "unpack out_valid", 64'(u_ov), 64'(um_cnt != 0));
      chk("R6", "unpack out_data", 64'(u_od), 64'(um_data[7:0]));
      chk("R6", "unpack fill", 64'(u_fill), 64'(um_cnt));
   endtask

   task automatic e_cmp();
      chk("R7", "equal in_ready", 64'(e_ir), 64'(em_cnt == 0));
      chk("R7", "equal out_valid", 64'(e_ov), 64'(em_cnt == 1));
      chk("R7", "equal out_data", 64'(e_od), 64'(em_data));
      chk("R7", "equal fill", 64'(e_fill), 64'(em_cnt));
   endtask

   // each step: drive at a falling edge, predict, cross one rising edge, compare
   task automatic p_step(input logic iv, input logic [7:0] id, input logic orr, input logic fl);
      p_iv = iv; p_id = id; p_or = orr; p_fl = fl;
      if (fl) begin pm_cnt = 0; pm_data = '0; end
      else if (iv && pm_cnt < 4) begin pm_data[pm_cnt*8 +: 8] = id; pm_cnt++; end
      else if (pm_cnt == 4 && orr) begin pm_cnt = 0; pm_data = '0; end
      @(negedge clk);
      p_iv = 0; p_or = 0; p_fl = 0;
      p_cmp();
   endtask

   task automatic u_step(input logic iv, input logic [31:0] id, input logic orr, input logic fl);
      u_iv = iv; u_id = id; u_or = orr; u_fl = fl;
      if (fl) begin um_cnt = 0; um_data = '0; end
      else if (iv && um_cnt == 0) begin um_data = id; um_cnt = 4; end
      else if (um_cnt != 0 && orr) begin um_data = um_data >> 8; um_cnt--; end
      @(negedge clk);
      u_iv = 0; u_or = 0; u_fl = 0;
      u_cmp();
   endtask

   task automatic e_step(input logic iv, input logic [15:0] id, input logic orr, input logic fl);
      e_iv = iv; e_id = id; e_or = orr; e_fl = fl;
      if (fl) begin em_cnt = 0; em_data = '0; end
      else if (iv && em_cnt == 0) begin em_data = id; em_cnt = 1; end
      else if (em_cnt == 1 && orr) begin em_cnt = 0; em_data = '0; end
      @(negedge clk);
      e_iv = 0; e_or = 0; e_fl = 0;
      e_cmp();
   endtask

   initial begin
      #(200000 * 4);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state on all three variants
      chk("R1", "pack fill", 64'(p_fill), 64'd0);
      chk("R1", "pack ready", 64'(p_ir), 64'd1);
      chk("R1", "pack valid", 64'(p_ov), 64'd0);
      chk("R1", "unpack ready/valid", 64'({u_ir, u_ov, u_fill}), 64'({1'b1, 1'b0, 3'd0}));
      chk("R1", "equal ready/valid", 64'({e_ir, e_ov, e_fill}), 64'({1'b1, 1'b0, 1'b0}));

      // ---- pack directed ----
      p_step(1, 8'h11, 0, 0);
      p_step(1, 8'h22, 0, 0);
      p_step(1, 8'h33, 0, 0);
      p_step(1, 8'h44, 0, 0);
      chk("R3", "pack assembled word", 64'(p_od), 64'h44332211);
      chk("R2", "pack valid when full", 64'(p_ov), 64'd1);
      p_step(1, 8'hEE, 0, 0);   // refused write, R9
      chk("R9", "pack data after refused write", 64'(p_od), 64'h44332211);
      chk("R9", "pack fill after refused write", 64'(p_fill), 64'd4);
      p_step(0, 8'h00, 0, 0);   // stall, R11
      chk("R11", "pack stalled data", 64'(p_od), 64'h44332211);
      p_step(0, 8'h00, 1, 0);
      chk("R4", "pack empty after read", 64'({p_ov, p_fill}), 64'd0);
      p_step(1, 8'hA1, 0, 0);
      p_step(1, 8'hA2, 0, 1);   // flush beats write, R8
      chk("R8", "pack fill after flush", 64'(p_fill), 64'd0);
      chk("R8", "pack data after flush", 64'(p_od), 64'd0);
      for (int i = 0; i < 400; i++)
         p_step(($urandom % 10) < 6, 8'($urandom), ($urandom % 2) == 1, ($urandom % 32) == 0);

      // ---- unpack directed ----
      u_step(1, 32'hDDCCBBAA, 0, 0);
      chk("R5", "unpack fill after load", 64'(u_fill), 64'd4);
      chk("R6", "unpack first piece", 64'(u_od), 64'hAA);
      u_step(1, 32'h12345678, 0, 0);   // refused write, R9
      chk("R9", "unpack data after refused write", 64'(u_od), 64'hAA);
      u_step(0, '0, 1, 0);
      chk("R6", "unpack second piece", 64'(u_od), 64'hBB);
      u_step(0, '0, 1, 0);
      chk("R6", "unpack third piece", 64'(u_od), 64'hCC);
      u_step(0, '0, 0, 0);
      chk("R11", "unpack stalled piece", 64'({u_od, u_fill}), 64'({8'hCC, 3'd2}));
      u_step(0, '0, 1, 0);
      chk("R6", "unpack last piece", 64'(u_od), 64'hDD);
      u_step(0, '0, 1, 1);   // flush beats read, R8
      chk("R8", "unpack empty after flush", 64'({u_ov, u_ir, u_fill}), 64'({1'b0, 1'b1, 3'd0}));
      for (int i = 0; i < 400; i++)
         u_step(($urandom % 10) < 5, $urandom, ($urandom % 3) != 0, ($urandom % 32) == 0);

      // ---- equal-width directed ----
      e_step(1, 16'h1234, 0, 0);
      e_step(1, 16'h5678, 0, 0);   // refused write, R9
      chk("R7", "equal data unchanged", 64'(e_od), 64'h1234);
      chk("R9", "equal fill after refused write", 64'(e_fill), 64'd1);
      e_step(0, '0, 1, 0);
      chk("R4", "equal empty after read", 64'({e_ov, e_fill}), 64'd0);
      e_step(1, 16'hBEEF, 1, 1);   // flush beats write, R8
      chk("R8", "equal empty after flush", 64'({e_ov, e_fill}), 64'd0);
      for (int i = 0; i < 300; i++)
         e_step(($urandom % 2) == 1, 16'($urandom), ($urandom % 2) == 1, ($urandom % 32) == 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule